// File: doc/BRIEF.md
# Halt, Wake-up and Reset Sequencer

This block decides when a small processor core may run. A one-cycle halt strobe from the core puts it into a low-power hold: the system clock enable drops and the core is frozen. The block keeps its own clock running, so it can watch for a way out of halt. The four wake events are an external reset, a new interrupt request, a falling edge on a port pin whose wake bit is set, and a watchdog overflow. After any wake, and after power-up, the core is held for a fixed start-up period while the oscillator settles. The clock enable is already on during that period.

Two status flags tell software why the core restarted. One is a time-out flag and the other is a power-down flag. The block also drives one-cycle cold-reset and warm-reset pulses to the core. A resume selector tells the released core whether to fetch the next instruction or take the interrupt vector. When a watchdog clocked from an independent oscillator is selected, the block clears it on halt entry.

Top module: `halt_wake_ctrl`

## Requirements
- R1: During the power-up reset and in the first cycle after it, cold_rst is 1, and it is 0 in the cycle after that. After power-up, flag_to=0 and flag_pdf=0.
- R2: A halt_req while running (with no ext_reset and no wdt_ovf in the same cycle) gives sys_clk_en=0, core_hold=1, flag_pdf=1 and flag_to=0 in the next cycle.
- R3: On halt entry, wdt_clr is high for exactly one cycle if wdt_osc_sel=1, and stays 0 if wdt_osc_sel=0.
- R4: A clrwdt_req while running clears flag_pdf and leaves flag_to unchanged.
- R5: During halt, a high-to-low transition on port_pins[i] wakes the block when port_wake_en[i]=1. A fall on a pin whose enable bit is 0 does not wake it, and neither does a rising transition. A port wake gives resume_vec=0 and leaves both flags unchanged.
- R6: During halt, a newly raised irq_req[i] wakes the block. resume_vec=1 only if irq_en[i]=1, irq_gie=1 and stack_full=0; otherwise resume_vec=0.
- R7: An irq_req bit that is already high when halt is entered does not wake the block while it stays high. Once it drops and rises again, it wakes the block.
- R8: A wdt_ovf during halt gives a one-cycle warm_rst pulse with cold_rst=0, and sets flag_to=1 and flag_pdf=1.
- R9: An ext_reset during halt gives a one-cycle cold_rst pulse, with flag_to=0 and flag_pdf=1.
- R10: An ext_reset while running gives a one-cycle cold_rst pulse. Both flags are unchanged and core_hold stays 0, so no start-up delay is added.
- R11: A wdt_ovf while running gives a one-cycle cold_rst pulse and sets flag_to=1. flag_pdf is unchanged and core_hold stays 0.
- R12: After every wake and after power-up, core_hold stays 1 for exactly STARTUP_CYCLES (default 1024) cycles with sys_clk_en=1, and then falls to 0.
- R13: When several wake events arrive in the same halt cycle, ext_reset wins over wdt_ovf, wdt_ovf wins over an interrupt, and an interrupt wins over a port edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock (never gated) |
| rst | input | 1 | Synchronous active-high power-up reset |
| halt_req | input | 1 | One-cycle strobe from the core's halt instruction |
| clrwdt_req | input | 1 | One-cycle strobe from the clear-watchdog instruction |
| ext_reset | input | 1 | External reset request, synchronised |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| wdt_osc_sel | input | 1 | 1 when the watchdog runs from an independent oscillator |
| irq_req | input | IRQ_N | Interrupt request flags |
| irq_en | input | IRQ_N | Per-source interrupt enables |
| irq_gie | input | 1 | Global interrupt enable |
| stack_full | input | 1 | Core return stack is full |
| port_pins | input | PORT_W | Wake-capable port pin levels |
| port_wake_en | input | PORT_W | Per-pin wake enables |
| sys_clk_en | output | 1 | System clock enable, 0 during halt |
| core_hold | output | 1 | Holds the core during halt and start-up |
| cold_rst | output | 1 | One-cycle full reset pulse to the core |
| warm_rst | output | 1 | One-cycle reset pulse for program counter and stack pointer only |
| resume_vec | output | 1 | 1 means take the interrupt vector on release; 0 means continue with the next instruction |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse on halt entry |
| flag_to | output | 1 | Time-out status flag |
| flag_pdf | output | 1 | Power-down status flag |

## Verification
Some checks run on every cycle:
- a halt request moves the flags and gates the clock;
- a clear-watchdog strobe touches only the power-down flag;
- a reset while running never holds the core;
- a warm reset always comes with both flags set and never with a cold pulse;
- the start-up counter is busy exactly while the phase is start-up, and it counts down by one per cycle.

Other behaviour only the bench scenarios can show:
- the full start-up length;
- which port pins and edge directions wake the block;
- the interrupt-vector decision over every enable and stack combination;
- masking of requests that were pending at halt entry;
- the priority between wake events that arrive together.

// File: rtl/hwk_pkg.sv
package hwk_pkg;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_HALT  = 2'd1,
    PH_START = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_EXT  = 3'd1,
    WK_WDT  = 3'd2,
    WK_IRQ  = 3'd3,
    WK_PORT = 3'd4
  } wake_e;

endpackage

// File: rtl/hwk_port_edge.sv
module hwk_port_edge #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pins,
  input  logic [PINS-1:0] wake_mask,
  output logic            any_fall
);

  logic [PINS-1:0] pin_q;
  logic [PINS-1:0] hit;

  // Sampled on the controller clock, which keeps running during halt.
  always_ff @(posedge clk) begin
    if (rst) pin_q <= pins;
    else     pin_q <= pins;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign hit[i] = pin_q[i] & ~pins[i] & wake_mask[i];
  end

  assign any_fall = |hit;

endmodule

// File: rtl/hwk_wake_qual.sv
module hwk_wake_qual
  import hwk_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm,
  input  logic            halted,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            gie,
  input  logic            stack_full,
  input  logic            ext_reset,
  input  logic            wdt_ovf,
  input  logic            port_fall,
  output wake_e           cause,
  output logic            vector_ok
);

  logic [NIRQ-1:0] stale_q;
  logic [NIRQ-1:0] fresh;

  // Requests pending at halt entry are masked until they drop.
  always_ff @(posedge clk) begin
    if (rst)         stale_q <= '0;
    else if (arm)    stale_q <= irq_req;
    else if (halted) stale_q <= stale_q & irq_req;
  end

  assign fresh     = irq_req & ~stale_q;
  assign vector_ok = gie & ~stack_full & |(fresh & irq_en);

  always_comb begin
    cause = WK_NONE;
    if (halted) begin
      if (ext_reset)    cause = WK_EXT;
      else if (wdt_ovf) cause = WK_WDT;
      else if (|fresh)  cause = WK_IRQ;
      else if (port_fall) cause = WK_PORT;
    end
  end

endmodule

// File: rtl/hwk_startup.sv
module hwk_startup #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy,
  output logic expire
);

  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      cnt_q <= LAST;
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) busy  <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = busy && (cnt_q == '0);

  // R12: one step down per cycle while the delay runs
  a_r12_count_down: assert property (@(posedge clk) disable iff (rst)
    (busy && !load && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwk_pkg::*;
#(
  parameter int PORT_W         = 8,
  parameter int IRQ_N          = 4,
  parameter int STARTUP_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic              clrwdt_req,
  input  logic              ext_reset,
  input  logic              wdt_ovf,
  input  logic              wdt_osc_sel,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic              irq_gie,
  input  logic              stack_full,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [PORT_W-1:0] port_wake_en,
  output logic              sys_clk_en,
  output logic              core_hold,
  output logic              cold_rst,
  output logic              warm_rst,
  output logic              resume_vec,
  output logic              wdt_clr,
  output logic              flag_to,
  output logic              flag_pdf
);

  phase_e phase_q;
  wake_e  cause;
  logic   vector_ok;
  logic   port_fall;
  logic   arm;
  logic   tmr_load;
  logic   tmr_busy;
  logic   tmr_expire;

  assign arm = (phase_q == PH_RUN) && halt_req && !ext_reset && !wdt_ovf;
  assign tmr_load = ((phase_q == PH_HALT) && (cause != WK_NONE)) ||
                    ((phase_q == PH_START) && ext_reset);

  hwk_port_edge #(.PINS(PORT_W)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .pins      (port_pins),
    .wake_mask (port_wake_en),
    .any_fall  (port_fall)
  );

  hwk_wake_qual #(.NIRQ(IRQ_N)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .halted     (phase_q == PH_HALT),
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .gie        (irq_gie),
    .stack_full (stack_full),
    .ext_reset  (ext_reset),
    .wdt_ovf    (wdt_ovf),
    .port_fall  (port_fall),
    .cause      (cause),
    .vector_ok  (vector_ok)
  );

  hwk_startup #(.CYCLES(STARTUP_CYCLES)) u_start (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .busy   (tmr_busy),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_START;
      flag_to    <= 1'b0;
      flag_pdf   <= 1'b0;
      cold_rst   <= 1'b1;
      warm_rst   <= 1'b0;
      wdt_clr    <= 1'b0;
      resume_vec <= 1'b0;
    end else begin
      cold_rst <= 1'b0;
      warm_rst <= 1'b0;
      wdt_clr  <= 1'b0;
      unique case (phase_q)
        PH_RUN: begin
          if (ext_reset) begin
            cold_rst   <= 1'b1;
            resume_vec <= 1'b0;
          end else if (wdt_ovf) begin
            cold_rst   <= 1'b1;
            flag_to    <= 1'b1;
            resume_vec <= 1'b0;
          end else if (halt_req) begin
            phase_q    <= PH_HALT;
            flag_pdf   <= 1'b1;
            flag_to    <= 1'b0;
            wdt_clr    <= wdt_osc_sel;
            resume_vec <= 1'b0;
          end else if (clrwdt_req) begin
            flag_pdf <= 1'b0;
          end
        end
        PH_HALT: begin
          unique case (cause)
            WK_EXT: begin
              phase_q    <= PH_START;
              cold_rst   <= 1'b1;
              flag_to    <= 1'b0;
              flag_pdf   <= 1'b1;
              resume_vec <= 1'b0;
            end
            WK_WDT: begin
              phase_q    <= PH_START;
              warm_rst   <= 1'b1;
              flag_to    <= 1'b1;
              flag_pdf   <= 1'b1;
              resume_vec <= 1'b0;
            end
            WK_IRQ: begin
              phase_q    <= PH_START;
              resume_vec <= vector_ok;
            end
            WK_PORT: begin
              phase_q    <= PH_START;
              resume_vec <= 1'b0;
            end
            default: phase_q <= PH_HALT;
          endcase
        end
        PH_START: begin
          if (ext_reset) begin
            cold_rst   <= 1'b1;
            resume_vec <= 1'b0;
          end else if (tmr_expire) begin
            phase_q <= PH_RUN;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign sys_clk_en = (phase_q != PH_HALT);
  assign core_hold  = (phase_q != PH_RUN);

  // R2: halt entry sets the power-down flag and gates the clock
  a_r2_halt_entry: assert property (@(posedge clk) disable iff (rst)
    arm |=> (flag_pdf && !flag_to && !sys_clk_en && core_hold));

  // R3: the watchdog clear never lasts more than one cycle
  a_r3_wdt_clr_pulse: assert property (@(posedge clk) disable iff (rst)
    wdt_clr |=> !wdt_clr);

  // R4: clear-watchdog touches only the power-down flag
  a_r4_clr_pdf: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_RUN) && clrwdt_req && !halt_req && !ext_reset && !wdt_ovf)
      |=> (!flag_pdf && $stable(flag_to)));

  // R8: warm reset always comes with both flags set and no cold pulse
  a_r8_warm_flags: assert property (@(posedge clk) disable iff (rst)
    warm_rst |-> (flag_to && flag_pdf && !cold_rst));

  // R8: warm reset is a single-cycle pulse
  a_r8_warm_pulse: assert property (@(posedge clk) disable iff (rst)
    warm_rst |=> !warm_rst);

  // R10: reset while running does not hold the core
  a_r10_run_reset: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_RUN) && ext_reset) |=> (cold_rst && !core_hold));

  // R12: start-up counter is busy exactly during the start-up phase
  a_r12_timer_phase: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_START) == tmr_busy));

endmodule

// File: tb/tb_halt_wake_ctrl.sv
module tb_halt_wake_ctrl;

  localparam int PW  = 8;
  localparam int NI  = 4;
  localparam int CYC = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          halt_req = 0, clrwdt_req = 0, ext_reset = 0, wdt_ovf = 0;
  logic          wdt_osc_sel = 0, irq_gie = 0, stack_full = 0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic [PW-1:0] port_pins = '1, port_wake_en = '0;
  logic sys_clk_en, core_hold, cold_rst, warm_rst, resume_vec, wdt_clr, flag_to, flag_pdf;

  int vectors = 0;
  int fails   = 0;
  logic e_to, e_pdf;

  always #2.5 clk = ~clk;

  halt_wake_ctrl #(.PORT_W(PW), .IRQ_N(NI), .STARTUP_CYCLES(CYC)) dut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .clrwdt_req(clrwdt_req),
    .ext_reset(ext_reset), .wdt_ovf(wdt_ovf), .wdt_osc_sel(wdt_osc_sel),
    .irq_req(irq_req), .irq_en(irq_en), .irq_gie(irq_gie), .stack_full(stack_full),
    .port_pins(port_pins), .port_wake_en(port_wake_en),
    .sys_clk_en(sys_clk_en), .core_hold(core_hold), .cold_rst(cold_rst),
    .warm_rst(warm_rst), .resume_vec(resume_vec), .wdt_clr(wdt_clr),
    .flag_to(flag_to), .flag_pdf(flag_pdf));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    check({tag, " flag_to"},  flag_to,  e_to);
    check({tag, " flag_pdf"}, flag_pdf, e_pdf);
  endtask

  task automatic enter_halt(input logic osc);
    wdt_osc_sel = osc;
    halt_req = 1'b1;
    tick();
    halt_req = 1'b0;
    e_pdf = 1'b1; e_to = 1'b0;
    check("R2 sys_clk_en", sys_clk_en, 0);
    check("R2 core_hold", core_hold, 1);
    check_flags("R2");
    check("R3 wdt_clr on entry", wdt_clr, osc);
    tick();
    check("R3 wdt_clr single", wdt_clr, 0);
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (core_hold === 1'b1 && n < 5000) begin
      if (sys_clk_en !== 1'b1) check("R12 clk_en during start-up", sys_clk_en, 1);
      n++;
      tick();
    end
  endtask

  initial begin
    int n;
    // R1 power-up
    repeat (3) @(posedge clk);
    tick();
    rst = 1'b0;
    e_to = 0; e_pdf = 0;
    check("R1 cold_rst after reset", cold_rst, 1);
    check_flags("R1");
    check("R12 clk_en at power-up", sys_clk_en, 1);
    tick();
    check("R1 cold_rst drops", cold_rst, 0);
    wait_release(n);
    check("R12 power-up hold length", n, CYC - 1);

    // R11 watchdog while running
    wdt_ovf = 1; tick(); wdt_ovf = 0;
    e_to = 1;
    check("R11 cold_rst", cold_rst, 1);
    check("R11 core_hold", core_hold, 0);
    check_flags("R11");
    tick();
    check("R11 pulse ends", cold_rst, 0);

    // R4 clear-watchdog: force pdf=1 by a halt/wake first
    enter_halt(1'b0);
    port_wake_en = 8'h01; port_pins[0] = 0; tick(); port_pins[0] = 1;
    wait_release(n);
    port_wake_en = '0;
    clrwdt_req = 1; tick(); clrwdt_req = 0;
    e_pdf = 0;
    check_flags("R4");

    // R10 external reset while running
    ext_reset = 1; tick(); ext_reset = 0;
    check("R10 cold_rst", cold_rst, 1);
    check("R10 core_hold", core_hold, 0);
    check_flags("R10");
    tick();
    check("R10 pulse ends", cold_rst, 0);
    check("R10 no start-up", core_hold, 0);

    // R5 port sweep
    for (int b = 0; b < PW; b++) begin
      port_wake_en = ~(PW'(1) << b);
      enter_halt(b[0]);
      port_pins[b] = 0; tick();
      check("R5 disabled pin no wake", sys_clk_en, 0);
      port_pins[b] = 1; tick();
      check("R5 rising edge no wake", sys_clk_en, 0);
      port_wake_en = PW'(1) << b;
      port_pins[b] = 0; tick();
      check("R5 enabled fall wakes", sys_clk_en, 1);
      check("R5 resume_vec", resume_vec, 0);
      check("R5 no cold", cold_rst, 0);
      check("R5 no warm", warm_rst, 0);
      check_flags("R5");
      port_pins[b] = 1;
      wait_release(n);
      check("R12 port wake hold length", n, CYC);
    end
    port_wake_en = '0;

    // R6 interrupt sweep
    for (int s = 0; s < NI; s++) begin
      for (int m = 0; m < 8; m++) begin
        irq_en     = m[0] ? (NI'(1) << s) : ~(NI'(1) << s);
        irq_gie    = m[1];
        stack_full = m[2];
        enter_halt(1'b0);
        irq_req[s] = 1; tick();
        check("R6 irq wakes", sys_clk_en, 1);
        check("R6 resume_vec", resume_vec, (m[0] && m[1] && !m[2]) ? 1 : 0);
        irq_req[s] = 0;
        wait_release(n);
      end
    end
    irq_en = '1; irq_gie = 1; stack_full = 0;

    // R7 pending request masked
    irq_req[2] = 1;
    enter_halt(1'b0);
    tick();
    check("R7 pending no wake", sys_clk_en, 0);
    irq_req[2] = 0; tick();
    check("R7 drop no wake", sys_clk_en, 0);
    irq_req[2] = 1; tick();
    check("R7 re-raise wakes", sys_clk_en, 1);
    check("R7 resume_vec", resume_vec, 1);
    irq_req[2] = 0;
    wait_release(n);

    // R8 watchdog during halt
    enter_halt(1'b1);
    wdt_ovf = 1; tick(); wdt_ovf = 0;
    e_to = 1; e_pdf = 1;
    check("R8 warm_rst", warm_rst, 1);
    check("R8 no cold", cold_rst, 0);
    check_flags("R8");
    tick();
    check("R8 warm single", warm_rst, 0);
    wait_release(n);
    check("R12 wdt wake hold length", n, CYC - 1);

    // R9 external reset during halt
    enter_halt(1'b0);
    ext_reset = 1; tick(); ext_reset = 0;
    e_to = 0; e_pdf = 1;
    check("R9 cold_rst", cold_rst, 1);
    check("R9 core_hold", core_hold, 1);
    check_flags("R9");
    tick();
    check("R9 pulse ends", cold_rst, 0);
    wait_release(n);

    // R13 priority: ext over wdt
    enter_halt(1'b0);
    ext_reset = 1; wdt_ovf = 1; tick(); ext_reset = 0; wdt_ovf = 0;
    check("R13 ext beats wdt cold", cold_rst, 1);
    check("R13 ext beats wdt warm", warm_rst, 0);
    check_flags("R13 ext");
    wait_release(n);
    // wdt over irq
    enter_halt(1'b0);
    wdt_ovf = 1; irq_req[1] = 1; tick(); wdt_ovf = 0; irq_req[1] = 0;
    e_to = 1; e_pdf = 1;
    check("R13 wdt beats irq warm", warm_rst, 1);
    check("R13 wdt beats irq vec", resume_vec, 0);
    check_flags("R13 wdt");
    wait_release(n);
    // irq over port
    enter_halt(1'b0);
    port_wake_en = 8'h10;
    irq_req[3] = 1; port_pins[4] = 0; tick(); irq_req[3] = 0; port_pins[4] = 1;
    e_pdf = 1; e_to = 0;
    check("R13 irq beats port vec", resume_vec, 1);
    check_flags("R13 irq");
    wait_release(n);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule